// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block converts a reference made of a segment identifier and an offset into a physical address. It uses a small table of segment descriptors held in registers on chip. Each descriptor gives a segment its base address, its length in bytes, separate read, write and execute permissions, and a flag that says whether the segment is resident. Software fills the table through a configuration write port, one entry per write. Each request carries a segment id, an offset and an access type. The registered response comes one cycle later and carries either a physical address or a single fault code.

When it checks a request, the translator looks for three conditions:

- a segment that is not resident;
- an offset at or beyond the segment length, or a segment id that has no table slot;
- an access type that the segment does not allow.

If more than one condition applies, the fault with the highest priority is reported.

A compatibility mode bypasses the table completely. The low 16 bits of the segment value are shifted left by four and added to the low 16 bits of the offset. The sum is kept to 20 bits, so it wraps past 0xFFFFF. No check of any kind is made in this mode.

Top module: `seg_xlate`

## Requirements
- R1: During reset `rsp_valid` is 0. After reset every table entry has its resident flag cleared, so a checked request to any in-table segment faults with code 1.
- R2: `rsp_valid` is 1 in exactly the cycle that follows a cycle with `req_valid` high, and 0 after a cycle without a request.
- R3: A checked request that raises no fault returns fault code 0 and address `base + offset`, taken modulo 2^32.
- R4: A checked request whose offset is greater than or equal to the segment length returns fault code 2 (bounds) and address 0.
- R5: Access types are encoded as 0 read, 1 write, 2 execute and 3 never permitted. Permission bits are bit 0 read, bit 1 write and bit 2 execute. An access type that the entry does not allow returns fault code 3 and address 0.
- R6: A checked request to an in-table entry whose resident flag is clear returns fault code 1 (not present) and address 0.
- R7: Fault priority is not-present, then bounds, then permission. Only the highest-priority fault code is reported.
- R8: A checked request with a segment id of 8 or more returns fault code 2, whatever the table contents are.
- R9: With `legacy_en` high the address is `(seg[15:0] << 4) + off[15:0]` modulo 2^20, zero-extended, and the fault code is 0. The table, the access type, the upper offset bits and the segment ids beyond the table have no effect.
- R10: A table write becomes visible to requests from the next cycle onwards. A request made in the same cycle as the write sees the old contents. A write changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_en | input | 1 | Selects the unchecked shifted-base mode for the request in this cycle |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 3 | Entry index to write |
| cfg_base | input | 32 | Segment base address |
| cfg_len | input | 32 | Segment length in bytes |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| cfg_present | input | 1 | Resident flag |
| req_valid | input | 1 | Request strobe |
| req_seg | input | 16 | Segment id |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 bounds, 3 permission |
| rsp_addr | output | 32 | Physical address, 0 on a fault |

## Verification
The bench targets several edges:

- **Length boundary.** It tests an offset of exactly length minus one against exactly the length. An off-by-one compare would accept the first byte past the end, or reject the last byte inside it.
- **Fault priority.** It builds requests that break all three rules at once. A design with the wrong ordering would report a bounds or permission fault on a non-resident segment.
- **Segment ids past the table.** It uses ids whose low bits alias a valid entry. A design that truncates the id would translate these instead of faulting.
- **Compatibility mode.** It uses maximal segment and offset values with high offset bits set. A design that missed the 20-bit wrap, or leaked the upper offset bits into the sum, would return an address above 0xFFFFF.
- **Write and request in the same cycle.** A design with write-through to the lookup would answer from the new entry rather than the old one.

// File: rtl/segxlt_pkg.sv
package segxlt_pkg;

    parameter int SEG_ENTRIES = 8;
    parameter int SEGID_W     = 16;
    parameter int OFF_W       = 32;
    parameter int PA_W        = 32;
    parameter int LEN_W       = 32;

    localparam int IDX_W      = $clog2(SEG_ENTRIES);
    localparam int LEG_SEG_W  = 16;
    localparam int LEG_SHIFT  = 4;
    localparam int LEG_AW     = LEG_SEG_W + LEG_SHIFT;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_RANGE  = 2'd2,
        FLT_PERM   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LEN_W-1:0] len;
        perm_t            perm;
        logic             present;
    } seg_desc_t;

    function automatic logic perm_allows(perm_t p, access_e a);
        case (a)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [LEG_AW-1:0] legacy_sum(logic [LEG_SEG_W-1:0] seg,
                                                      logic [LEG_SEG_W-1:0] off);
        return {seg, {LEG_SHIFT{1'b0}}} + {{LEG_SHIFT{1'b0}}, off};
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import segxlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  seg_desc_t          wr_desc,
    input  logic [SEGID_W-1:0] rd_seg,
    output seg_desc_t          rd_desc,
    output logic               rd_in_range
);

    seg_desc_t ent [SEG_ENTRIES];

    for (genvar i = 0; i < SEG_ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent[i] <= wr_desc;
            end
        end

        // R10: a write lands in the addressed entry on the next cycle
        assert_entry_load_R10: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx == IDX_W'(i)) |=> (ent[i] == $past(wr_desc)));

        // R10: other entries are left alone by a write
        assert_entry_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_idx != IDX_W'(i)) |=> $stable(ent[i]));
    end

    assign rd_in_range = (rd_seg < SEGID_W'(SEG_ENTRIES));
    assign rd_desc     = ent[rd_seg[IDX_W-1:0]];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import segxlt_pkg::*;
(
    input  seg_desc_t        desc,
    input  logic             in_range,
    input  logic [OFF_W-1:0] off,
    input  access_e          acc,
    output fault_e           fault
);

    logic beyond_len;
    logic allowed;

    assign beyond_len = (LEN_W'(off) >= desc.len);
    assign allowed    = perm_allows(desc.perm, acc);

    // priority order: missing slot, not resident, length, permission
    always_comb begin
        if (!in_range)          fault = FLT_RANGE;
        else if (!desc.present) fault = FLT_ABSENT;
        else if (beyond_len)    fault = FLT_RANGE;
        else if (!allowed)      fault = FLT_PERM;
        else                    fault = FLT_NONE;
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segxlt_pkg::*;
(
    input  logic               legacy,
    input  logic [SEGID_W-1:0] seg,
    input  logic [OFF_W-1:0]   off,
    input  logic [PA_W-1:0]    base,
    output logic [PA_W-1:0]    addr
);

    logic [LEG_AW-1:0] leg_addr;
    logic [PA_W-1:0]   chk_addr;

    assign leg_addr = legacy_sum(seg[LEG_SEG_W-1:0], off[LEG_SEG_W-1:0]);
    assign chk_addr = base + PA_W'(off);
    assign addr     = legacy ? PA_W'(leg_addr) : chk_addr;

    // R9: the compatibility sum never leaves the 20-bit window
    always_comb begin
        if (legacy) begin
            assert_legacy_window_R9: assert (addr < PA_W'(1 << LEG_AW));
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segxlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               legacy_en,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PA_W-1:0]    cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [2:0]         cfg_perm,
    input  logic               cfg_present,
    input  logic               req_valid,
    input  logic [SEGID_W-1:0] req_seg,
    input  logic [OFF_W-1:0]   req_off,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic [1:0]         rsp_fault,
    output logic [PA_W-1:0]    rsp_addr
);

    seg_desc_t       wr_desc;
    seg_desc_t       lk_desc;
    logic            lk_in_range;
    fault_e          chk_fault;
    fault_e          fault_now;
    logic [PA_W-1:0] gen_addr;
    logic [PA_W-1:0] addr_now;
    fault_e          fault_q;

    assign wr_desc = '{base: cfg_base, len: cfg_len, perm: perm_t'(cfg_perm),
                       present: cfg_present};

    seg_desc_table u_table (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_idx),
        .wr_desc     (wr_desc),
        .rd_seg      (req_seg),
        .rd_desc     (lk_desc),
        .rd_in_range (lk_in_range)
    );

    seg_check u_check (
        .desc     (lk_desc),
        .in_range (lk_in_range),
        .off      (req_off),
        .acc      (access_e'(req_acc)),
        .fault    (chk_fault)
    );

    seg_addr_gen u_addr (
        .legacy (legacy_en),
        .seg    (req_seg),
        .off    (req_off),
        .base   (lk_desc.base),
        .addr   (gen_addr)
    );

    assign fault_now = legacy_en ? FLT_NONE : chk_fault;
    assign addr_now  = (fault_now == FLT_NONE) ? gen_addr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            fault_q   <= FLT_NONE;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= req_valid;
            fault_q   <= fault_now;
            rsp_addr  <= addr_now;
        end
    end

    assign rsp_fault = fault_q;

    // R2: a request is answered on the next cycle, and only then
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R9: compatibility requests never fault
    assert_legacy_clean_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && legacy_en) |=> (rsp_fault == FLT_NONE));

    // R8: ids without a table slot give the bounds fault
    assert_id_range_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !legacy_en && !lk_in_range) |=> (rsp_fault == FLT_RANGE));

    // R6, R7: a non-resident in-table entry wins over every other fault
    assert_absent_first_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !legacy_en && lk_in_range && !lk_desc.present)
        |=> (rsp_fault == FLT_ABSENT));

    // R4: any fault carries a zero address
    assert_fault_addr_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_addr == '0));

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        legacy_en;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_base;
    logic [31:0] cfg_len;
    logic [2:0]  cfg_perm;
    logic        cfg_present;
    logic        req_valid;
    logic [15:0] req_seg;
    logic [31:0] req_off;
    logic [1:0]  req_acc;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_addr;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_base [8];
    logic [31:0] m_len  [8];
    logic [2:0]  m_perm [8];
    logic        m_pres [8];

    always #10 clk = ~clk;

    seg_xlate dut (
        .clk(clk), .rst(rst), .legacy_en(legacy_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .cfg_perm(cfg_perm), .cfg_present(cfg_present),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [33:0] expect_rsp(input logic [15:0] seg, input logic [31:0] off,
                                               input logic [1:0] acc, input logic leg);
        logic [1:0]  f;
        logic [31:0] a;
        logic        ok;
        if (leg) begin
            f = 2'd0;
            a = ((32'(seg) << 4) + 32'(off[15:0])) & 32'h000F_FFFF;
        end else begin
            if (seg >= 16'd8) f = 2'd2;
            else if (!m_pres[seg[2:0]]) f = 2'd1;
            else if (off >= m_len[seg[2:0]]) f = 2'd2;
            else begin
                ok = (acc == 2'd0) ? m_perm[seg[2:0]][0] :
                     (acc == 2'd1) ? m_perm[seg[2:0]][1] :
                     (acc == 2'd2) ? m_perm[seg[2:0]][2] : 1'b0;
                f = ok ? 2'd0 : 2'd3;
            end
            a = (f == 2'd0) ? m_base[seg[2:0]] + off : 32'd0;
        end
        return {f, a};
    endfunction

    task automatic write_ent(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] l,
                             input logic [2:0] p, input logic pr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = b; cfg_len = l; cfg_perm = p; cfg_present = pr;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[idx] = b; m_len[idx] = l; m_perm[idx] = p; m_pres[idx] = pr;
    endtask

    task automatic do_req(input string tag, input logic [15:0] seg, input logic [31:0] off,
                          input logic [1:0] acc, input logic leg);
        logic [33:0] e;
        e = expect_rsp(seg, off, acc, leg);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc; legacy_en = leg;
        @(negedge clk);
        req_valid = 1'b0; legacy_en = 1'b0;
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " fault"}, 64'(rsp_fault), 64'(e[33:32]));
        chk({tag, " addr"},  64'(rsp_addr),  64'(e[31:0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_len[i] = '0; m_perm[i] = '0; m_pres[i] = 1'b0;
        end
        rst = 1'b1; legacy_en = 0; cfg_we = 0; cfg_idx = 0; cfg_base = 0; cfg_len = 0;
        cfg_perm = 0; cfg_present = 0; req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
        repeat (3) @(negedge clk);
        chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;

        // R1 / R6: cleared table reports not present
        do_req("R1 empty table", 16'd3, 32'd0, 2'd0, 1'b0);

        // R2: idle cycle gives no response
        @(negedge clk);
        chk("R2 no stray response", 64'(rsp_valid), 64'd0);

        write_ent(3'd0, 32'h1000_0000, 32'h100, 3'b011, 1'b1);
        write_ent(3'd1, 32'hFFFF_FFF0, 32'h40,  3'b111, 1'b1);
        write_ent(3'd2, 32'h0002_0000, 32'h10,  3'b100, 1'b1);
        write_ent(3'd3, 32'h0003_0000, 32'h10,  3'b001, 1'b0);
        write_ent(3'd4, 32'h0004_0000, 32'h0,   3'b111, 1'b1);
        write_ent(3'd5, 32'h0005_0000, 32'h80,  3'b010, 1'b1);

        do_req("R3 read in bounds", 16'd0, 32'h20, 2'd0, 1'b0);
        do_req("R3 32-bit wrap", 16'd1, 32'h20, 2'd1, 1'b0);
        do_req("R4 last byte", 16'd0, 32'hFF, 2'd1, 1'b0);
        do_req("R4 one past end", 16'd0, 32'h100, 2'd0, 1'b0);
        do_req("R4 zero length", 16'd4, 32'h0, 2'd0, 1'b0);
        do_req("R5 execute denied", 16'd0, 32'h4, 2'd2, 1'b0);
        do_req("R5 execute allowed", 16'd2, 32'h4, 2'd2, 1'b0);
        do_req("R5 read denied", 16'd2, 32'h4, 2'd0, 1'b0);
        do_req("R5 reserved type", 16'd1, 32'h4, 2'd3, 1'b0);
        do_req("R6 not present", 16'd3, 32'h1, 2'd0, 1'b0);
        do_req("R7 absent over range and perm", 16'd3, 32'h500, 2'd2, 1'b0);
        do_req("R7 range over perm", 16'd2, 32'h500, 2'd0, 1'b0);
        do_req("R8 id 8 aliasing entry 0", 16'd8, 32'h4, 2'd0, 1'b0);
        do_req("R8 id FFFF", 16'hFFFF, 32'h0, 2'd0, 1'b0);
        do_req("R9 max wrap", 16'hFFFF, 32'h0000_FFFF, 2'd3, 1'b1);
        do_req("R9 plain sum", 16'h1234, 32'h5678, 2'd0, 1'b1);
        do_req("R9 high offset ignored", 16'd3, 32'hABCD_0010, 2'd2, 1'b1);
        do_req("R9 id beyond table", 16'd9, 32'h10, 2'd1, 1'b1);

        // R10: write and request in the same cycle see the old entry
        begin
            logic [33:0] e;
            e = expect_rsp(16'd5, 32'h8, 2'd1, 1'b0);
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 3'd5; cfg_base = 32'h0; cfg_len = 32'h80;
            cfg_perm = 3'b010; cfg_present = 1'b0;
            req_valid = 1'b1; req_seg = 16'd5; req_off = 32'h8; req_acc = 2'd1;
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            m_pres[5] = 1'b0; m_base[5] = 32'h0;
            chk("R10 same-cycle fault", 64'(rsp_fault), 64'(e[33:32]));
            chk("R10 same-cycle addr", 64'(rsp_addr), 64'(e[31:0]));
        end
        do_req("R10 new entry visible", 16'd5, 32'h8, 2'd1, 1'b0);
        do_req("R10 neighbour untouched", 16'd0, 32'h8, 2'd0, 1'b0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                write_ent(3'($urandom_range(0, 7)), $urandom(), 32'($urandom_range(0, 300)),
                          3'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0));
            end
            do_req("R3 R4 R5 R7 R8 R9 random",
                   ($urandom_range(0, 5) == 0) ? 16'($urandom()) : 16'($urandom_range(0, 9)),
                   ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 320)),
                   2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 4) == 0));
        end

        summary();
        $finish;
    end

endmodule